// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a two-wire bus slave that lets a host reach a bank of sixteen byte-wide registers held in the surrounding core. The bus lines arrive as plain inputs that the block oversamples with its own system clock. The only thing the block drives back onto the bus is an enable that pulls the data line low. A two-bit strap picks one of three bus addresses, and a fourth strap code takes the slave off the bus.

A host first writes a command byte, marked by its top bit. The command loads a persistent four-bit register pointer and a block-transfer flag. Later write bytes go into the register bank, and read bytes come out of it, starting at that pointer. Word and block transfers step the working address upward and wrap within the sixteen registers. The stored pointer itself is never moved by data traffic.

In a block write, the byte count sent by the host is acknowledged and thrown away, and the length is whatever arrives before the stop. The block also recognises the alert-response address and flags it, but does not acknowledge it. On the core side there is a one-cycle write strobe, a one-cycle read strobe and a shared register address.

Top module: `smbus_reg_slave`

## Requirements
- R1: After reset the slave does not pull the data line low, the write and read strobes are low, and the stored pointer is 0.
- R2: The bus address is 7'h29 for strap code 00, 7'h39 for 01 and 7'h49 for 10. Strap code 11 matches no address. An address that does not match is not acknowledged, and the slave ignores the rest of that transfer.
- R3: The slave acknowledges a matching address, and every byte written to it, by pulling the data line low for the ninth clock of that byte.
- R4: The first byte after a write address is a command byte when its bit 7 is 1. Bits 3:0 become the stored pointer and bit 4 becomes the block flag. A command byte is never written to a register.
- R5: When the first byte after a write address has bit 7 equal to 0, it is written as data to the register selected by the stored pointer.
- R6: Data bytes in a write go to the pointer, then pointer+1, and so on, modulo 16. The stored pointer is unchanged afterwards.
- R7: A read transfer returns the register at the stored pointer. Each byte the host acknowledges is followed by the next register, modulo 16.
- R8: When the block flag is set, the byte right after the command byte is acknowledged and discarded. The bytes after it are written until the stop.
- R9: When the block flag is set, a read transfer first returns a count byte equal to 16 (8'h10). After that it returns the registers from the stored pointer onward.
- R10: After the host answers a read byte with a NACK, the slave stops driving the data line until the next start.
- R11: A header carrying the alert-response address 7'h0C raises a one-cycle alert pulse and is not acknowledged.
- R12: A start or stop that arrives in the middle of a byte abandons the transfer. Nothing is written, and the stored pointer keeps its value.
- R13: The pull-down enable changes only while the synchronised clock line is low, or at a detected start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_sel | input | 2 | Address strap: 00 low, 01 float, 10 high, 11 off |
| sda_pull | output | 1 | 1 pulls the data line low |
| alert_hit | output | 1 | One-cycle pulse when the alert-response address is seen |
| reg_addr | output | 4 | Register address presented to the core |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_data | input | 8 | Register read data for reg_addr, combinational |

## Verification
A corrupt stored pointer shows up on the very next receive transfer: the first byte out comes from the wrong register. A wrong working address shows up within one byte as a write to the wrong register, which the bench-side register model exposes. A state machine that misses a start, stop or acknowledge shows up within one bit time, either as an acknowledge bit that is absent or unwanted, or as the data line still held low after a NACK. Abort and strap-off cases are observed through the absence of write strobes and acknowledges, followed by a read-back through a clean transfer.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BIT, ST_WR_ACK,
    ST_RD_LOAD, ST_RD_BIT, ST_RD_ACK, ST_SKIP
  } xfer_st_e;

  localparam logic [6:0] ALERT_ADDR = 7'h0C;
  localparam logic [6:0] BASE_ADDR  = 7'h29;

  // strap code n selects BASE_ADDR + 16*n; code 3 is off
  function automatic logic [6:0] strap_addr(input logic [1:0] code);
    return BASE_ADDR + {1'b0, code, 4'b0000};
  endfunction

  function automatic logic strap_on(input logic [1:0] code);
    return code != 2'b11;
  endfunction
endpackage

// File: rtl/smbus_line_cond.sv
module smbus_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/smbus_addr_match.sv
module smbus_addr_match (
  input  logic [6:0] hdr_addr,
  input  logic [1:0] strap_sel,
  output logic       self_hit,
  output logic       alert_match
);
  import smbus_pkg::*;

  assign self_hit    = strap_on(strap_sel) && (hdr_addr == strap_addr(strap_sel));
  assign alert_match = (hdr_addr == ALERT_ADDR);
endmodule

// File: rtl/smbus_xfer_fsm.sv
module smbus_xfer_fsm #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          self_hit,
  input  logic          alert_match,
  input  logic [DW-1:0] reg_rd_data,
  output logic [6:0]    hdr_addr,
  output logic          sda_pull,
  output logic          alert_hit,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd_en,
  output logic          addr_ack_evt,
  output logic          host_nack_evt,
  output logic [AW-1:0] ptr_q
);
  import smbus_pkg::*;

  localparam int CW = $clog2(DW + 1);
  localparam int NREG = 1 << AW;
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [DW-1:0] COUNT_BYTE = DW'(NREG);

  xfer_st_e      st;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur_q;
  logic          rw_q, first_q, cnt_pend_q, blk_q, rd_count_q, host_ack_q;
  logic          pull_q, wr_en_q, rd_en_q, alert_q;
  logic [DW-1:0] wr_data_q;
  logic [DW-1:0] load_byte;
  logic          byte_in_done;

  assign hdr_addr      = sh[DW-1:DW-7];
  assign load_byte     = rd_count_q ? COUNT_BYTE : reg_rd_data;
  assign byte_in_done  = scl_fall && (cnt == FULL);
  assign addr_ack_evt  = (st == ST_ADDR) && byte_in_done && self_hit;
  assign host_nack_evt = (st == ST_RD_ACK) && scl_fall && !host_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sh         <= '0;
      cnt        <= '0;
      cur_q      <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      cnt_pend_q <= 1'b0;
      blk_q      <= 1'b0;
      rd_count_q <= 1'b0;
      host_ack_q <= 1'b0;
      pull_q     <= 1'b0;
      wr_en_q    <= 1'b0;
      rd_en_q    <= 1'b0;
      alert_q    <= 1'b0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      rd_en_q <= 1'b0;
      alert_q <= 1'b0;
      if (wr_en_q) cur_q <= cur_q + 1'b1;
      if (start_det) begin
        st         <= ST_ADDR;
        cnt        <= '0;
        pull_q     <= 1'b0;
        cnt_pend_q <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        pull_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_in_done) begin
              if (self_hit) begin
                pull_q <= 1'b1;
                rw_q   <= sh[0];
                cur_q  <= ptr_q;
                st     <= ST_ADDR_ACK;
              end else begin
                alert_q <= alert_match;
                st      <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              if (!rw_q) begin
                st      <= ST_WR_BIT;
                cnt     <= '0;
                first_q <= 1'b1;
              end else begin
                st         <= ST_RD_LOAD;
                rd_en_q    <= ~blk_q;
                rd_count_q <= blk_q;
              end
            end
          end
          ST_WR_BIT: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_in_done) begin
              pull_q  <= 1'b1;
              st      <= ST_WR_ACK;
              first_q <= 1'b0;
              if (first_q && sh[DW-1]) begin
                ptr_q      <= sh[AW-1:0];
                cur_q      <= sh[AW-1:0];
                blk_q      <= sh[AW];
                cnt_pend_q <= sh[AW];
              end else if (cnt_pend_q) begin
                cnt_pend_q <= 1'b0;
              end else begin
                wr_en_q   <= 1'b1;
                wr_data_q <= sh;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              cnt    <= '0;
              st     <= ST_WR_BIT;
            end
          end
          ST_RD_LOAD: begin
            sh     <= load_byte;
            pull_q <= ~load_byte[DW-1];
            cnt    <= CW'(1);
            st     <= ST_RD_BIT;
          end
          ST_RD_BIT: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                pull_q <= 1'b0;
                st     <= ST_RD_ACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                pull_q <= ~sh[DW-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_ack_q <= ~sda_s;
              if (!sda_s && !rd_count_q) cur_q <= cur_q + 1'b1;
            end else if (scl_fall) begin
              if (host_ack_q) begin
                rd_en_q    <= 1'b1;
                rd_count_q <= 1'b0;
                st         <= ST_RD_LOAD;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull    = pull_q;
  assign alert_hit   = alert_q;
  assign reg_addr    = cur_q;
  assign reg_wr_en   = wr_en_q;
  assign reg_wr_data = wr_data_q;
  assign reg_rd_en   = rd_en_q;
endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [1:0]    strap_sel,
  output logic          sda_pull,
  output logic          alert_hit,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rd_data
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] hdr_addr;
  logic       self_hit, alert_match, addr_ack_evt, host_nack_evt;
  logic [AW-1:0] ptr_q;

  smbus_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbus_addr_match u_match (
    .hdr_addr(hdr_addr), .strap_sel(strap_sel),
    .self_hit(self_hit), .alert_match(alert_match)
  );

  smbus_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .self_hit(self_hit), .alert_match(alert_match), .reg_rd_data(reg_rd_data),
    .hdr_addr(hdr_addr), .sda_pull(sda_pull), .alert_hit(alert_hit),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .addr_ack_evt(addr_ack_evt),
    .host_nack_evt(host_nack_evt), .ptr_q(ptr_q)
  );
endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] strap_sel,
  input logic       sda_pull,
  input logic       alert_hit,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       addr_ack_evt,
  input logic       host_nack_evt
);
  // R13
  pull_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!$past(scl_s) || $past(start_det || stop_det)));
  // R2
  off_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_evt |-> (strap_sel != 2'b11));
  // R3
  addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_evt |=> sda_pull);
  // R10
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_nack_evt |=> !sda_pull);
  // R11
  alert_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_hit |-> !sda_pull);
  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  // R12
  abort_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !reg_wr_en);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
endmodule

bind smbus_reg_slave smbus_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .sda_pull(sda_pull),
  .alert_hit(alert_hit), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .addr_ack_evt(addr_ack_evt), .host_nack_evt(host_nack_evt)
);

// File: tb/tb_smbus_reg_slave.sv
module tb_smbus_reg_slave;
  localparam int CLK_NS = 10;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0] strap_sel = 2'b00;
  logic sda_pull, alert_hit, reg_wr_en, reg_rd_en;
  logic [3:0] reg_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic sda_line;
  logic [7:0] regs [16];
  int checks = 0, failures = 0, wr_count = 0, alert_count = 0;
  logic done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;
  assign reg_rd_data = regs[reg_addr];

  smbus_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .strap_sel(strap_sel), .sda_pull(sda_pull), .alert_hit(alert_hit),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'hC0 | 8'(i);
      wr_count <= 0;
      alert_count <= 0;
    end else begin
      if (reg_wr_en) begin
        regs[reg_addr] <= reg_wr_data;
        wr_count <= wr_count + 1;
      end
      if (alert_hit) alert_count <= alert_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q);
    sda_drv = 1'b0; w(Q); scl_drv = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; w(Q); scl_drv = 1'b1; w(Q);
    sda_drv = 1'b1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; w(Q); scl_drv = 1'b1; w(2*Q); scl_drv = 1'b0; w(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q);
    ack = ~sda_line; w(Q); scl_drv = 1'b0; w(Q);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q);
      d[i] = sda_line; w(Q); scl_drv = 1'b0; w(Q);
    end
    send_bit(~give_ack);
  endtask

  task automatic cmd_write(input logic [7:0] cmd);
    logic a;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(cmd, a); bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 pull", sda_pull, 0);
    chk("R1 wr_en", reg_wr_en, 0);
    chk("R1 rd_en", reg_rd_en, 0);
  endtask

  task automatic t_receive(input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    bus_start(); write_byte({7'h29, 1'b1}, a);
    chk({req, " addr ack"}, a, 1);
    read_byte(1'b0, d);
    chk({req, " receive data"}, d, exp);
    w(Q);
    chk("R10 released after nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_write_byte();
    logic a1, a2, a3;
    bus_start(); write_byte({7'h29, 1'b0}, a1); write_byte(8'h83, a2); write_byte(8'h5A, a3); bus_stop();
    chk("R3 addr ack", a1, 1);
    chk("R3 cmd ack", a2, 1);
    chk("R3 data ack", a3, 1);
    chk("R6 reg3 written", regs[3], 8'h5A);
    chk("R4 cmd not written", wr_count, 1);
  endtask

  task automatic t_send_data();
    logic a;
    int wc = wr_count;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(8'h37, a); bus_stop();
    chk("R5 msb0 written to ptr", regs[3], 8'h37);
    chk("R5 one write", wr_count - wc, 1);
  endtask

  task automatic t_write_word();
    logic a;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(8'h8F, a);
    write_byte(8'h11, a); write_byte(8'h22, a); bus_stop();
    chk("R6 reg15", regs[15], 8'h11);
    chk("R6 wrap reg0", regs[0], 8'h22);
  endtask

  task automatic t_read_word();
    logic a; logic [7:0] d0, d1;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(8'h8F, a);
    bus_start(); write_byte({7'h29, 1'b1}, a);
    read_byte(1'b1, d0); read_byte(1'b0, d1); bus_stop();
    chk("R7 word lo", d0, 8'h11);
    chk("R7 word wrap", d1, 8'h22);
  endtask

  task automatic t_block_write();
    logic a; int wc = wr_count;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(8'h94, a);
    write_byte(8'h03, a);
    chk("R8 count acked", a, 1);
    write_byte(8'hA1, a); write_byte(8'hA2, a); write_byte(8'hA3, a); bus_stop();
    chk("R8 reg4", regs[4], 8'hA1);
    chk("R8 reg6", regs[6], 8'hA3);
    chk("R8 three writes", wr_count - wc, 3);
    chk("R8 count discarded reg3", regs[3], 8'h37);
  endtask

  task automatic t_block_read();
    logic a; logic [7:0] d;
    bus_start(); write_byte({7'h29, 1'b0}, a); write_byte(8'h94, a);
    bus_start(); write_byte({7'h29, 1'b1}, a);
    read_byte(1'b1, d); chk("R9 count byte", d, 8'h10);
    read_byte(1'b1, d); chk("R9 first reg", d, 8'hA1);
    read_byte(1'b1, d); chk("R9 second reg", d, 8'hA2);
    read_byte(1'b0, d); chk("R9 third reg", d, 8'hA3);
    bus_stop();
  endtask

  task automatic probe(input logic [6:0] adr, input logic exp, input string req);
    logic a;
    bus_start(); write_byte({adr, 1'b0}, a); bus_stop();
    chk(req, a, exp);
  endtask

  task automatic t_straps();
    strap_sel = 2'b01; w(4);
    probe(7'h39, 1, "R2 strap01 0x39");
    probe(7'h29, 0, "R2 strap01 rejects 0x29");
    strap_sel = 2'b10; w(4);
    probe(7'h49, 1, "R2 strap10 0x49");
    strap_sel = 2'b11; w(4);
    probe(7'h29, 0, "R2 off 0x29");
    probe(7'h39, 0, "R2 off 0x39");
    probe(7'h49, 0, "R2 off 0x49");
    strap_sel = 2'b00; w(4);
  endtask

  task automatic t_alert();
    int ac = alert_count;
    probe(7'h0C, 0, "R11 alert not acked");
    chk("R11 alert pulse", alert_count - ac, 1);
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d; int wc;
    cmd_write(8'h83);
    wc = wr_count;
    bus_start(); write_byte({7'h29, 1'b0}, a);
    send_bit(1); send_bit(0); send_bit(0); send_bit(0);
    bus_stop();
    chk("R12 stop abort no write", wr_count - wc, 0);
    t_receive(8'h37, "R12 ptr kept after stop");
    bus_start(); write_byte({7'h29, 1'b0}, a);
    send_bit(1); send_bit(0); send_bit(1);
    bus_start(); write_byte({7'h29, 1'b1}, a);
    read_byte(1'b0, d); bus_stop();
    chk("R12 start abort read", d, 8'h37);
    chk("R12 start abort no write", wr_count - wc, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset();
    t_write_byte();
    t_receive(8'h5A, "R7");
    t_send_data();
    t_write_word();
    t_receive(8'h11, "R6 ptr unchanged");
    t_read_word();
    t_block_write();
    t_block_read();
    t_straps();
    t_alert();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule